// File: doc/BRIEF.md
# Serial Drive Command and Status Exchanger

This block is the controller-side sequencer for one serial exchange with one of up to four disk drives. When software starts an operation it places the unit number on a 2-bit select bus. It then waits a settling pause. After that it shifts a 16-bit command word out on a serial command line. The word is timed by a free-running system clock that the block generates and sends to the drive.

For a status request, the block then takes in a 16-bit status word. The drive sends it on a status data line together with a status clock that the drive returns. For a positioning (seek) operation, the exchange ends once the command word has gone out. A seek also waits for drive-ready before it transmits; a status request never waits for it.

On completion the block raises controller-ready. It also raises an interrupt request when the interrupt enable was set. A watchdog on the status clock ends a status exchange that the drive never answers, and flags an error.

Top module: `drvx_exchanger`

## Requirements
- R1: After reset: `ctl_ready`=1, `irq_req`=0, `sel_out`=0, `cmd_en`=0, `cmd_out`=0, `stat_word`=0, `stat_err`=0.
- R2: A `start` pulse taken while `ctl_ready`=1 copies `unit_sel` onto `sel_out` on the next clock. `sel_out` then holds that value through the exchange and after it. A `start` while `ctl_ready`=0 is ignored: it leaves `sel_out` and the exchange unchanged.
- R3: `cmd_en` does not rise earlier than SETTLE_CYC+1 clocks after the clock that accepted `start`.
- R4: The command word is sent MSB first, 16 bits. Each bit is valid at a rising edge of `sys_clk_o` while `cmd_en`=1, and changes only when `sys_clk_o` falls. The first bit (word bit 15) is always 1, as a marker, whatever `cmd_word[15]` holds. Bits 14..0 are sent as given, including bit 3, which asks the drive to clear its error.
- R5: `cmd_en` is high for exactly 16 `sys_clk_o` periods per exchange. `cmd_en` and `cmd_out` are 0 at all other times, including while `ctl_ready`=1.
- R6: A seek (`op_get_stat`=0) does not start shifting while `drv_rdy`=0. It proceeds once `drv_rdy`=1. A status request (`op_get_stat`=1) proceeds and completes with `drv_rdy`=0.
- R7: In a status request the block samples `stat_dat` at each rising edge of `stat_clk` after the command word ends. The 16 bits are taken MSB first, and the whole word appears on `stat_word` at completion.
- R8: At completion `ctl_ready` returns to 1, and `irq_req` becomes the value of `irq_en`. `irq_req` then holds until the next accepted `start`. A seek completes right after its 16th command bit, without waiting for any status clock.
- R9: If 64 `sys_clk_o` periods pass in a status request with no `stat_clk` rising edge, the exchange ends. Then `stat_err`=1, `ctl_ready`=1, `irq_req`=`irq_en`, and `stat_word` keeps its previous value.
- R10: An accepted `start` clears `irq_req` and `stat_err` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exchange (taken only when ready) |
| op_get_stat | input | 1 | 1 = status request, 0 = seek |
| unit_sel | input | 2 | Drive number from the control register |
| cmd_word | input | 16 | Command word to transmit |
| irq_en | input | 1 | Interrupt enable |
| drv_rdy | input | 1 | Drive-ready from the selected drive |
| stat_clk | input | 1 | Status clock returned by the drive |
| stat_dat | input | 1 | Serial status data from the drive |
| sel_out | output | 2 | Drive select lines |
| sys_clk_o | output | 1 | Free-running system clock to the drives |
| cmd_en | output | 1 | Command line enabled |
| cmd_out | output | 1 | Serial command data |
| ctl_ready | output | 1 | Controller ready (idle) |
| irq_req | output | 1 | Interrupt request |
| stat_word | output | 16 | Last captured status word |
| stat_err | output | 1 | Status clock timeout |

## Verification
A vector table runs seeks and status requests on each of the four units with several command words. One word has bit 15 clear, which shows that the marker is forced. Another has only bit 3 set beside the marker. A third alternates bits, which exposes any bit slip or reversal. The status words include all ones, a single MSB, a single LSB and a mixed pattern, so that an order error, a shift error or a stuck capture each gives a different result.

Directed runs then cover the remaining cases. A seek is held off by a low drive-ready. A status request completes with drive-ready low. An unanswered status request shows the timeout and the preserved status word. A start arrives during a busy exchange. Interrupt and error flags are cleared by a following start.

// File: rtl/drvx_pkg.sv
package drvx_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SHIFT  = 2'd2,
    ST_CAPT   = 2'd3
  } xch_state_t;

  // force the leading marker bit so the drive can frame the word
  function automatic logic [WORD_W-1:0] marked_cmd(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[WORD_W-1] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/drvx_sysclk.sv
module drvx_sysclk #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sys_clk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == CW'(HALF - 1));
  assign rise_tick = wrap & ~sys_clk;
  assign fall_tick = wrap & sys_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sys_clk <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      sys_clk <= ~sys_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/drvx_cmd_shift.sv
module drvx_cmd_shift #(
  parameter int BITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] word,
  input  logic            fall_tick,
  input  logic            rise_tick,
  output logic            cmd_en,
  output logic            cmd_out,
  output logic            done
);
  localparam int CW = $clog2(BITS + 1);
  logic [BITS-1:0] sreg;
  logic [CW-1:0]   cnt;
  logic            active;
  logic            last_bit_out;

  assign last_bit_out = active && fall_tick && (cnt == CW'(BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      cnt     <= '0;
      active  <= 1'b0;
      cmd_en  <= 1'b0;
      cmd_out <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sreg   <= word;
        cnt    <= '0;
        active <= 1'b1;
      end else if (last_bit_out) begin
        cmd_en  <= 1'b0;
        cmd_out <= 1'b0;
        active  <= 1'b0;
        done    <= 1'b1;
      end else if (active && fall_tick) begin
        cmd_en  <= 1'b1;
        cmd_out <= sreg[BITS-1];
        sreg    <= {sreg[BITS-2:0], 1'b0};
        cnt     <= cnt + 1'b1;
      end
    end
  end

  // R4: command data moves only on a falling system clock
  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && $past(cmd_en) && !$stable(cmd_out)) |-> $past(fall_tick));
  // R4: data is steady across each sampling (rising) edge
  a_r4_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && rise_tick) |=> $stable(cmd_out));
  // R5: enable never outlives the bit count
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |-> (cnt <= CW'(BITS)));
endmodule

// File: rtl/drvx_stat_capt.sv
module drvx_stat_capt #(
  parameter int BITS = 16,
  parameter int TMO  = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            stat_clk,
  input  logic            stat_dat,
  input  logic            rise_tick,
  output logic [BITS-1:0] word,
  output logic            done,
  output logic            timeout
);
  localparam int CW = $clog2(BITS + 1);
  localparam int TW = $clog2(TMO + 1);
  logic [1:0]      sclk_sync, sdat_sync;
  logic            sclk_prev;
  logic            edge_seen;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   idle_per;
  logic            active;

  assign edge_seen = sclk_sync[1] & ~sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      sdat_sync <= '0;
      sclk_prev <= 1'b0;
      word      <= '0;
      cnt       <= '0;
      idle_per  <= '0;
      active    <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[0], stat_clk};
      sdat_sync <= {sdat_sync[0], stat_dat};
      sclk_prev <= sclk_sync[1];
      done      <= 1'b0;
      timeout   <= 1'b0;
      if (arm) begin
        cnt      <= '0;
        idle_per <= '0;
        active   <= 1'b1;
      end else if (active && edge_seen) begin
        word     <= {word[BITS-2:0], sdat_sync[1]};
        idle_per <= '0;
        cnt      <= cnt + 1'b1;
        if (cnt == CW'(BITS - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end else if (active && rise_tick) begin
        if (idle_per == TW'(TMO - 1)) begin
          active  <= 1'b0;
          timeout <= 1'b1;
        end else begin
          idle_per <= idle_per + 1'b1;
        end
      end
    end
  end

  // R9: the two endings of a capture exclude each other
  a_r9_one_ending: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  // R9: idle counter never runs past its limit
  a_r9_tmo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idle_per < TW'(TMO)));
endmodule

// File: rtl/drvx_exchanger.sv
module drvx_exchanger
  import drvx_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int SYS_HALF   = 2,
  parameter int TMO_PER    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_get_stat,
  input  logic [1:0]        unit_sel,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              irq_en,
  input  logic              drv_rdy,
  input  logic              stat_clk,
  input  logic              stat_dat,
  output logic [1:0]        sel_out,
  output logic              sys_clk_o,
  output logic              cmd_en,
  output logic              cmd_out,
  output logic              ctl_ready,
  output logic              irq_req,
  output logic [WORD_W-1:0] stat_word,
  output logic              stat_err
);
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  xch_state_t        state;
  logic [SW-1:0]     scnt;
  logic              op_q;
  logic [WORD_W-1:0] cmd_q;
  logic              rise_tick, fall_tick;
  logic              accept, settle_end, load_cmd, arm_capt, finish;
  logic              sh_done, cap_done, cap_tmo;
  logic [WORD_W-1:0] cap_word;

  assign accept     = (state == ST_IDLE) && start;
  assign settle_end = (state == ST_SETTLE) && (scnt == SW'(SETTLE_CYC - 1));
  assign load_cmd   = settle_end && (op_q || drv_rdy);
  assign arm_capt   = (state == ST_SHIFT) && sh_done && op_q;
  assign finish     = ((state == ST_SHIFT) && sh_done && !op_q) ||
                      ((state == ST_CAPT) && (cap_done || cap_tmo));

  drvx_sysclk #(.HALF(SYS_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .sys_clk(sys_clk_o),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  drvx_cmd_shift #(.BITS(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(load_cmd), .word(cmd_q),
    .fall_tick(fall_tick), .rise_tick(rise_tick),
    .cmd_en(cmd_en), .cmd_out(cmd_out), .done(sh_done)
  );

  drvx_stat_capt #(.BITS(WORD_W), .TMO(TMO_PER)) u_rx (
    .clk(clk), .rst_n(rst_n), .arm(arm_capt), .stat_clk(stat_clk),
    .stat_dat(stat_dat), .rise_tick(rise_tick), .word(cap_word),
    .done(cap_done), .timeout(cap_tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      scnt      <= '0;
      op_q      <= 1'b0;
      cmd_q     <= '0;
      sel_out   <= '0;
      ctl_ready <= 1'b1;
      irq_req   <= 1'b0;
      stat_word <= '0;
      stat_err  <= 1'b0;
    end else begin
      if (accept) begin
        sel_out   <= unit_sel;
        op_q      <= op_get_stat;
        cmd_q     <= marked_cmd(cmd_word);
        ctl_ready <= 1'b0;
        irq_req   <= 1'b0;
        stat_err  <= 1'b0;
        scnt      <= '0;
        state     <= ST_SETTLE;
      end
      if (state == ST_SETTLE && !settle_end) scnt <= scnt + 1'b1;
      if (load_cmd) state <= ST_SHIFT;
      if (arm_capt) state <= ST_CAPT;
      if (state == ST_CAPT && cap_done) stat_word <= cap_word;
      if (state == ST_CAPT && cap_tmo) stat_err <= 1'b1;
      if (finish) begin
        ctl_ready <= 1'b1;
        irq_req   <= irq_en;
        state     <= ST_IDLE;
      end
    end
  end

  // R2: select lines hold while an exchange runs
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_ready && $past(!ctl_ready)) |-> $stable(sel_out));
  // R5: no command traffic while idle
  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ready |-> (!cmd_en && !cmd_out));
  // R6: a seek never loads its word while the drive is not ready
  a_r6_seek_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cmd && !op_q) |-> drv_rdy);
  // R8: an interrupt only appears together with ready
  a_r8_irq_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ctl_ready);
  // R10: an accepted start drops both flags
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!irq_req && !stat_err && !ctl_ready));
endmodule

// File: tb/tb_drvx_exchanger.sv
module tb_drvx_exchanger;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_get_stat = 1'b0, irq_en = 1'b0, drv_rdy = 1'b1;
  logic        stat_clk = 1'b0, stat_dat = 1'b0;
  logic [1:0]  unit_sel = 2'd0;
  logic [15:0] cmd_word = 16'h0;
  logic [1:0]  sel_out;
  logic        sys_clk_o, cmd_en, cmd_out, ctl_ready, irq_req, stat_err;
  logic [15:0] stat_word;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drvx_exchanger #(.SETTLE_CYC(SETTLE), .SYS_HALF(2), .TMO_PER(64)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_get_stat(op_get_stat),
    .unit_sel(unit_sel), .cmd_word(cmd_word), .irq_en(irq_en),
    .drv_rdy(drv_rdy), .stat_clk(stat_clk), .stat_dat(stat_dat),
    .sel_out(sel_out), .sys_clk_o(sys_clk_o), .cmd_en(cmd_en),
    .cmd_out(cmd_out), .ctl_ready(ctl_ready), .irq_req(irq_req),
    .stat_word(stat_word), .stat_err(stat_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // fields: op(1) unit(2) irq_en(1) cmd(16) status(16)
  localparam int NV = 6;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 2'd1, 1'b1, 16'h0005, 16'h0000},
    {1'b1, 2'd2, 1'b1, 16'h0008, 16'hA5C3},
    {1'b1, 2'd3, 1'b0, 16'h8000, 16'hFFFF},
    {1'b1, 2'd0, 1'b1, 16'h7FFF, 16'h0001},
    {1'b0, 2'd2, 1'b0, 16'hAAAA, 16'h0000},
    {1'b1, 2'd1, 1'b1, 16'h1234, 16'h8000}
  };

  logic [15:0] got_cmd;
  int          settle_seen;

  task automatic wait_ready(input string tag);
    int n = 0;
    while (!ctl_ready && n < 3000) begin @(negedge clk); n++; end
    check(tag, {31'd0, ctl_ready}, 32'd1);
  endtask

  // one exchange; hold_rdy delays drive-ready, poke issues a start while busy, answer=0 leaves the drive silent
  task automatic run_xch(input logic op, input logic [1:0] unit, input logic ie,
                         input logic [15:0] cmd, input logic [15:0] stat,
                         input bit answer, input bit hold_rdy, input bit poke);
    int n;
    @(negedge clk);
    op_get_stat = op; unit_sel = unit; irq_en = ie; cmd_word = cmd;
    drv_rdy = hold_rdy ? 1'b0 : (op ? 1'b0 : 1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 irq cleared by start", {31'd0, irq_req}, 32'd0);
    check("R10 err cleared by start", {31'd0, stat_err}, 32'd0);
    check("R2 select loaded", {30'd0, sel_out}, {30'd0, unit});
    if (poke) begin
      @(negedge clk);
      unit_sel = ~unit; op_get_stat = ~op; cmd_word = 16'h0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 busy start ignored", {30'd0, sel_out}, {30'd0, unit});
    end
    if (hold_rdy) begin
      repeat (40) @(negedge clk);
      check("R6 seek held while not ready", {31'd0, cmd_en}, 32'd0);
      drv_rdy = 1'b1;
    end
    n = 1;
    while (!cmd_en && n < 500) begin @(negedge clk); n++; end
    settle_seen = n;
    if (!poke && !hold_rdy)
      check("R3 settle pause", {31'd0, (settle_seen > SETTLE)}, 32'd1);
    for (int i = 15; i >= 0; i--) begin
      @(posedge sys_clk_o);
      got_cmd[i] = cmd_out;
      if (!cmd_en) got_cmd[i] = 1'bx;
    end
    @(negedge clk);
    n = 0;
    while (cmd_en && n < 20) begin @(negedge clk); n++; end
    check("R4 command bits", {16'd0, got_cmd}, {16'd0, cmd | 16'h8000});
    check("R5 enable width 16 periods", {31'd0, (n <= 4)}, 32'd1);
    if (op && answer) begin
      repeat (3) @(negedge clk);
      for (int i = 15; i >= 0; i--) begin
        stat_dat = stat[i];
        repeat (4) @(negedge clk);
        stat_clk = 1'b1;
        repeat (4) @(negedge clk);
        stat_clk = 1'b0;
      end
    end
    wait_ready("R8 ready at completion");
    check("R8 irq follows enable", {31'd0, irq_req}, {31'd0, ie});
    check("R5 line quiet after exchange", {30'd0, cmd_en, cmd_out}, 32'd0);
    check("R2 select held after exchange", {30'd0, sel_out}, {30'd0, unit});
    drv_rdy = 1'b1;
  endtask

  initial begin
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    check("R1 ready", {31'd0, ctl_ready}, 32'd1);
    check("R1 irq", {31'd0, irq_req}, 32'd0);
    check("R1 select", {30'd0, sel_out}, 32'd0);
    check("R1 cmd line", {30'd0, cmd_en, cmd_out}, 32'd0);
    check("R1 status", {15'd0, stat_err, stat_word}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_xch(VEC[v][35], VEC[v][34:33], VEC[v][32], VEC[v][31:16], VEC[v][15:0], 1'b1, 1'b0, 1'b0);
      if (VEC[v][35]) check("R7 status word", {16'd0, stat_word}, {16'd0, VEC[v][15:0]});
      check("R9 no error on answered exchange", {31'd0, stat_err}, 32'd0);
    end

    // R6: seek waits for ready; status ran with drv_rdy low in the table
    run_xch(1'b0, 2'd3, 1'b1, 16'h0123, 16'h0, 1'b0, 1'b1, 1'b0);

    // R2: start during busy is ignored
    run_xch(1'b1, 2'd2, 1'b1, 16'h4001, 16'h5A5A, 1'b1, 1'b0, 1'b1);
    check("R7 status after ignored start", {16'd0, stat_word}, 16'h5A5A);

    // R9: silent drive times out, status word kept
    prev = stat_word;
    run_xch(1'b1, 2'd1, 1'b1, 16'h0002, 16'h0, 1'b0, 1'b0, 1'b0);
    check("R9 timeout error", {31'd0, stat_err}, 32'd1);
    check("R9 status kept", {16'd0, stat_word}, {16'd0, prev});

    // R10: next exchange clears the error and succeeds
    run_xch(1'b1, 2'd0, 1'b0, 16'h0009, 16'h3C0F, 1'b1, 1'b0, 1'b0);
    check("R10 error gone after good run", {31'd0, stat_err}, 32'd0);
    check("R7 status after recovery", {16'd0, stat_word}, 16'h3C0F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule